// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Register Access

This block is an SPI peripheral for an 8-bit processor bus. Software sets it up and runs it through three registers: control, status and data. It can work as bus master or as bus slave. As master it divides the local clock to make the serial clock and starts one byte transfer each time software writes the data register. As slave it takes the serial clock, the data-in line and an active-low select from outside. It passes them through a small synchronizer and follows the external edges.

Each transfer is full duplex and goes most-significant bit first through a single shift register. One bit goes out and one bit comes in on every serial clock cycle. When the eighth bit has been sampled, the received byte is copied into a receive buffer and the done flag is set. The done flag drives the interrupt line directly. The block also detects three error cases: a write collision, a slave whose select rises in the middle of a byte, and a master whose select input is pulled low by another master. Each error sets its own sticky flag. The pins are plain level signals with separate output-enable signals, so the pad ring can make them bidirectional.

Top module: `spi_regctl`

## Requirements
- R1: Register map on `bus_addr`: 0 is control, 1 is status, 2 is data. Control bits are [7] enable, [6] select-check disable, [5] master, [4] clock polarity, [3] clock phase and [2:0] rate code. Status bits are [0] done, [1] collision, [2] select error and [3] mode fault. After reset, control, status, `irq` and all output enables read 0.
- R2: A master transfer starts on a data-register write. It shifts the written byte out on `mosi_out`, MSB first, and at the same time collects eight bits from `miso_in`. At the end, reading the data register returns the collected byte, status bit 0 is set and `irq` is high.
- R3: The idle level of `sck_out` equals the polarity bit. With phase 0, data is sampled on the first edge of each bit and changed on the second. With phase 1, data is changed on the first edge and sampled on the second. All four polarity/phase combinations work in both roles.
- R4: In master mode each half period of `sck_out` lasts 2^(code+1) clock cycles for rate codes 0 to 5 (divide by 4 up to 128). The reserved codes 6 and 7 behave like code 5.
- R5: In slave mode with `ssn_in` low, the block exchanges a byte on edges of `sck_in`. It samples `mosi_in` and drives `miso_out` with the byte last written to the data register. The byte it receives is readable from the data register and sets the done flag.
- R6: A slave with `ssn_in` high keeps `miso_oe` low and ignores all `sck_in` activity: no flag is set and no bit is counted.
- R7: A data-register write during a transfer sets the collision flag (status bit 1). The written byte is dropped and the running transfer completes unchanged.
- R8: In master mode with select-check disable at 0, a low `ssn_in` sets the mode-fault flag (status bit 3), clears the master bit, aborts any transfer and drops `sck_oe` and `mosi_oe`. With select-check disable at 1, a low `ssn_in` has no effect on the master.
- R9: In slave mode, if `ssn_in` rises after at least one clock edge of a byte but before the byte ends, the select-error flag (status bit 2) is set and the bit counter restarts. The next full byte then transfers correctly.
- R10: A read of the status register followed by any access to the data register clears exactly the flags that were set at the time of that status read. A data access with no status read before it leaves the flags unchanged.
- R11: `sck_oe` and `mosi_oe` are high exactly when the block is enabled as master. `miso_oe` is high only when the block is an enabled slave that is selected. The master and slave output enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_rd | input | 1 | Read qualifier for the access |
| bus_addr | input | 2 | Register select (0 control, 1 status, 2 data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request, follows the done flag |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| mosi_in | input | 1 | Slave-mode serial data input |
| mosi_out | output | 1 | Master-mode serial data output |
| mosi_oe | output | 1 | Output enable for the master data pin |
| miso_in | input | 1 | Master-mode serial data input |
| miso_out | output | 1 | Slave-mode serial data output |
| miso_oe | output | 1 | Output enable for the slave data pin |
| ssn_in | input | 1 | Active-low slave select input |

## Verification
The bench builds the block with its default two-stage input synchronizer. Its slave-mode stimulus leaves eight clock cycles between external edges, which covers the three-cycle latency from pin to edge detection in every polarity/phase mode. Master runs use rate codes 0, 1, 2 and the reserved code 7. These include the fastest divider, where only two clock cycles separate a bench-driven data change from the sampling edge, and they show that the reserved code falls back to the slowest rate.

// File: rtl/spi_regctl_pkg.sv
package spi_regctl_pkg;

    localparam int BYTE_W = 8;
    localparam int RATE_W = 3;
    localparam int MAX_RATE_CODE = 5;
    localparam int HALF_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef struct packed {
        logic              en;
        logic              ssdis;
        logic              mstr;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic modf;
        logic sserr;
        logic wcol;
        logic done;
    } flags_t;

    // Half period of the master serial clock in peripheral clock cycles.
    function automatic logic [HALF_W-1:0] half_period(input logic [RATE_W-1:0] code);
        logic [RATE_W-1:0] c;
        c = (code > RATE_W'(MAX_RATE_CODE)) ? RATE_W'(MAX_RATE_CODE) : code;
        return HALF_W'(2) << c;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int              STAGES  = 2,
    parameter int              N       = 1,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import spi_regctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] lim;

    assign lim  = half_period(rate) - HALF_W'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + HALF_W'(1);
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         lead,
    input  logic         trail,
    input  logic         cpha,
    input  logic         din,
    output logic         dout,
    output logic         done,
    output logic [W-1:0] rx,
    output logic         midbyte
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sreg;
    logic [W-1:0]  shifted;
    logic [CW-1:0] bitcnt;
    logic          half_q;
    logic          last;

    assign shifted = {sreg[W-2:0], din};
    assign last    = (bitcnt == CW'(W-1));
    assign done    = trail && last && !clr && !load;
    assign rx      = cpha ? shifted : sreg;
    assign midbyte = (bitcnt != '0) || half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '0;
            dout   <= 1'b0;
            bitcnt <= '0;
            half_q <= 1'b0;
        end else if (load) begin
            sreg   <= load_data;
            dout   <= load_data[W-1];
            bitcnt <= '0;
            half_q <= 1'b0;
        end else if (clr) begin
            bitcnt <= '0;
            half_q <= 1'b0;
        end else begin
            if (lead) begin
                half_q <= 1'b1;
                if (cpha) dout <= sreg[W-1];
                else      sreg <= shifted;
            end
            if (trail) begin
                half_q <= 1'b0;
                bitcnt <= last ? '0 : bitcnt + CW'(1);
                if (cpha) sreg <= shifted;
                else      dout <= sreg[W-1];
            end
        end
    end
endmodule

// File: rtl/spi_regctl.sv
module spi_regctl
    import spi_regctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ssn_in
);
    ctrl_t             ctrl;
    flags_t            flags, seen;
    logic [BYTE_W-1:0] rxbuf, eng_rx;
    logic              busy, sck_act, tick;
    logic              sck_s, mosi_s, ssn_s, sck_p, ssn_p;
    logic              is_master, is_slave, sel, fault, ss_err;
    logic              lead, trail, sck_edge, eng_clr, eng_load, eng_done, eng_dout, midbyte;
    logic              wr_ctrl, wr_data, rd_stat, acc_data, xfer_busy, collide, start;

    spi_in_sync #(.STAGES(SYNC_STAGES), .N(3), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst(rst), .d({sck_in, mosi_in, ssn_in}), .q({sck_s, mosi_s, ssn_s})
    );

    spi_sck_divider u_div (
        .clk(clk), .rst(rst), .run(busy), .rate(ctrl.rate), .tick(tick)
    );

    assign is_master = ctrl.en && ctrl.mstr;
    assign is_slave  = ctrl.en && !ctrl.mstr;
    assign sel       = is_slave && !ssn_s;
    assign sck_edge  = sck_s ^ sck_p;
    assign fault     = is_master && !ctrl.ssdis && !ssn_s;
    assign ss_err    = is_slave && ssn_s && !ssn_p && midbyte;

    assign lead  = is_master ? (tick && !sck_act) : (sel && sck_edge && (sck_s ^ ctrl.cpol));
    assign trail = is_master ? (tick && sck_act)  : (sel && sck_edge && !(sck_s ^ ctrl.cpol));

    assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data   = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
    assign rd_stat   = bus_sel && bus_rd && (bus_addr == ADDR_STAT);
    assign acc_data  = bus_sel && (bus_wr || bus_rd) && (bus_addr == ADDR_DATA);
    assign xfer_busy = busy || (is_slave && midbyte);
    assign collide   = wr_data && xfer_busy;
    assign eng_load  = wr_data && !xfer_busy;
    assign start     = eng_load && is_master && !fault;
    assign eng_clr   = !ctrl.en || fault || ss_err;

    spi_shift_engine #(.W(BYTE_W)) u_eng (
        .clk(clk), .rst(rst), .clr(eng_clr), .load(eng_load), .load_data(bus_wdata),
        .lead(lead), .trail(trail), .cpha(ctrl.cpha),
        .din(is_master ? miso_in : mosi_s),
        .dout(eng_dout), .done(eng_done), .rx(eng_rx), .midbyte(midbyte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= 1'b0;
            ssn_p <= 1'b1;
        end else begin
            sck_p <= sck_s;
            ssn_p <= ssn_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sck_act <= 1'b0;
        end else begin
            if (fault || !is_master) busy <= 1'b0;
            else if (start)          busy <= 1'b1;
            else if (eng_done)       busy <= 1'b0;
            if (!busy)               sck_act <= 1'b0;
            else if (tick)           sck_act <= !sck_act;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            flags <= '0;
            seen  <= '0;
            rxbuf <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
            if (fault)   ctrl.mstr <= 1'b0;

            if (rd_stat)       seen <= flags;
            else if (acc_data) seen <= '0;

            flags <= (acc_data ? (flags & ~seen) : flags)
                   | {fault, ss_err, collide, eng_done};

            if (eng_done) rxbuf <= eng_rx;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl;
            ADDR_STAT: bus_rdata = {{(BYTE_W-4){1'b0}}, flags};
            ADDR_DATA: bus_rdata = rxbuf;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq      = flags.done;
    assign sck_oe   = is_master;
    assign mosi_oe  = is_master;
    assign sck_out  = ctrl.cpol ^ sck_act;
    assign mosi_out = eng_dout;
    assign miso_oe  = sel;
    assign miso_out = eng_dout;
endmodule

// File: rtl/spi_regctl_sva.sv
module spi_regctl_sva (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe,
    input logic       sck_out,
    input logic       irq,
    input logic       done,
    input logic       busy,
    input logic       wcol,
    input logic       modf,
    input logic       ssn_s,
    input logic       cpol
);
    assert_oe_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> (!sck_oe && !mosi_oe));

    assert_irq_after_done_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> irq);

    assert_fault_release_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(modf) |-> (!sck_oe && !mosi_oe));

    assert_collision_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 2'd2 && busy) |=> wcol);

    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (sck_oe && !busy && !$past(busy)) |-> (sck_out == cpol));

    assert_unselected_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ssn_s |-> !miso_oe);
endmodule

bind spi_regctl spi_regctl_sva u_sva (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe), .sck_out(sck_out),
    .irq(irq), .done(eng_done), .busy(busy), .wcol(flags.wcol), .modf(flags.modf),
    .ssn_s(ssn_s), .cpol(ctrl.cpol)
);

// File: tb/spi_regctl_test.sv
module spi_regctl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;
    logic       sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0, ssn_in = 1'b1;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    spi_regctl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe), .ssn_in(ssn_in)
    );

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    // Status read followed by a data read: clears the flags seen (R10).
    task automatic clear_flags();
        logic [7:0] t;
        bus_read(2'd1, t);
        bus_read(2'd2, t);
    endtask

    task automatic test_reset();
        bus_read(2'd0, rv); chk("R1 control after reset", rv, 8'h00);
        bus_read(2'd1, rv); chk("R1 status after reset", rv, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        chk("R11 enables after reset", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h00);
    endtask

    // The bench acts as an external slave; checks data, rate and flags.
    task automatic master_xfer(input logic cpol, input logic cpha, input logic [2:0] code,
                               input logic [7:0] mtx, input logic [7:0] stx);
        logic [7:0] cap = 8'h00;
        logic       prev;
        int         sbit = 7;
        int         half_meas = 0;
        int         half_exp;
        half_exp = 2 << ((code > 3'd5) ? 5 : int'(code));
        bus_write(2'd0, {1'b1, 1'b0, 1'b1, cpol, cpha, code});
        chk("R3 idle clock level", {7'd0, sck_out}, {7'd0, cpol});
        chk("R11 master enables", {6'd0, sck_oe, mosi_oe}, 8'h03);
        if (!cpha) begin miso_in = stx[7]; sbit = 6; end
        bus_write(2'd2, mtx);
        prev = sck_out;
        for (int e = 0; e < 16; e++) begin
            int n = 0;
            do begin @(negedge clk); n++; end while (sck_out == prev && n < 1000);
            prev = sck_out;
            if (e == 1) half_meas = n;
            if ((e % 2 == 0) == !cpha) cap = {cap[6:0], mosi_out};
            else if (sbit >= 0) begin miso_in = stx[sbit]; sbit--; end
        end
        wait_clks(2);
        chk("R4 half period", 8'(half_meas), 8'(half_exp));
        chk("R3 clock returns idle", {7'd0, sck_out}, {7'd0, cpol});
        chk("R2 MOSI byte MSB first", cap, mtx);
        chk("R2 irq after transfer", {7'd0, irq}, 8'h01);
        bus_read(2'd1, rv); chk("R2 done flag", rv, 8'h01);
        bus_read(2'd2, rv); chk("R2 received byte", rv, stx);
        bus_read(2'd1, rv); chk("R10 flags cleared", rv, 8'h00);
    endtask

    // The bench acts as the external master with eight clocks per half period.
    task automatic slave_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] stx, input logic [7:0] btx);
        logic [7:0] cap = 8'h00;
        int oe_ok = 1;
        bus_write(2'd0, {1'b1, 1'b0, 1'b0, cpol, cpha, 3'd0});
        sck_in = cpol;
        wait_clks(4);
        bus_write(2'd2, stx);
        ssn_in = 1'b0;
        wait_clks(4);
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_in = btx[i]; wait_clks(8);
                cap = {cap[6:0], miso_out}; oe_ok &= int'(miso_oe);
                sck_in = ~cpol; wait_clks(8);
                sck_in = cpol;
            end else begin
                sck_in = ~cpol; mosi_in = btx[i]; wait_clks(8);
                cap = {cap[6:0], miso_out}; oe_ok &= int'(miso_oe);
                sck_in = cpol; wait_clks(8);
            end
        end
        wait_clks(6);
        ssn_in = 1'b1;
        wait_clks(6);
        chk("R11 slave drives while selected", 8'(oe_ok), 8'h01);
        chk("R6 slave releases MISO", {7'd0, miso_oe}, 8'h00);
        chk("R5 MISO byte", cap, stx);
        bus_read(2'd1, rv); chk("R5 done flag", rv, 8'h01);
        bus_read(2'd2, rv); chk("R5 received byte", rv, btx);
        bus_read(2'd1, rv); chk("R10 flags cleared after slave", rv, 8'h00);
    endtask

    task automatic test_unselected();
        int oe_seen = 0;
        bus_write(2'd0, 8'h80);
        ssn_in = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sck_in = ~sck_in; mosi_in = i[0];
            wait_clks(6);
            oe_seen |= int'(miso_oe);
        end
        chk("R6 no MISO drive while deselected", 8'(oe_seen), 8'h00);
        bus_read(2'd1, rv); chk("R6 no flag while deselected", rv, 8'h00);
        chk("R6 no irq while deselected", {7'd0, irq}, 8'h00);
        sck_in = 1'b0;
        wait_clks(4);
    endtask

    task automatic test_select_error();
        bus_write(2'd0, 8'h80);
        sck_in = 1'b0;
        ssn_in = 1'b0;
        wait_clks(4);
        for (int i = 0; i < 3; i++) begin
            sck_in = 1'b1; wait_clks(8);
            sck_in = 1'b0; wait_clks(8);
        end
        ssn_in = 1'b1;
        wait_clks(6);
        bus_read(2'd1, rv); chk("R9 select error flag", rv, 8'h04);
        bus_read(2'd2, rv);
        bus_read(2'd1, rv); chk("R9 flag cleared", rv, 8'h00);
        slave_xfer(1'b0, 1'b0, 8'h69, 8'h96);
    endtask

    task automatic test_collision();
        int n = 0;
        bus_write(2'd0, 8'hA5);
        miso_in = 1'b1;
        bus_write(2'd2, 8'h3C);
        wait_clks(20);
        bus_write(2'd2, 8'hC3);
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        wait_clks(2);
        bus_read(2'd2, rv); chk("R7 running transfer intact", rv, 8'hFF);
        bus_read(2'd1, rv); chk("R10 data access alone keeps flags", rv, 8'h03);
        bus_read(2'd2, rv);
        bus_read(2'd1, rv); chk("R7 flags cleared", rv, 8'h00);
        chk("R7 dropped write starts nothing", {7'd0, sck_out}, 8'h00);
    endtask

    task automatic test_mode_fault();
        bus_write(2'd0, 8'hE0);
        ssn_in = 1'b0;
        wait_clks(5);
        chk("R8 select ignored when check disabled", {7'd0, sck_oe}, 8'h01);
        bus_read(2'd1, rv); chk("R8 no fault when check disabled", rv, 8'h00);
        bus_write(2'd0, 8'hA0);
        wait_clks(4);
        chk("R8 master drivers released", {6'd0, sck_oe, mosi_oe}, 8'h00);
        bus_read(2'd0, rv); chk("R8 master bit cleared", rv, 8'h80);
        bus_read(2'd1, rv); chk("R8 mode fault flag", rv, 8'h08);
        ssn_in = 1'b1;
        bus_read(2'd2, rv);
        wait_clks(4);
        bus_read(2'd1, rv); chk("R8 fault flag cleared", rv, 8'h00);
    endtask

    initial begin
        wait_clks(3);
        rst = 1'b0;
        wait_clks(2);
        test_reset();
        master_xfer(1'b0, 1'b0, 3'd0, 8'hA5, 8'h5A);
        master_xfer(1'b1, 1'b1, 3'd2, 8'h81, 8'h7E);
        master_xfer(1'b0, 1'b1, 3'd7, 8'hC4, 8'h2B);
        master_xfer(1'b1, 1'b0, 3'd1, 8'h0F, 8'hF0);
        slave_xfer(1'b0, 1'b0, 8'hB6, 8'h4D);
        slave_xfer(1'b1, 1'b1, 8'h13, 8'hEC);
        slave_xfer(1'b0, 1'b1, 8'h80, 8'h01);
        test_unselected();
        test_select_error();
        test_collision();
        test_mode_fault();
        report();
    end
endmodule